// File: doc/BRIEF.md
# Dual-Radio GPIO Source Steering

This block connects a 12-pin front-panel GPIO bank to two independent radio-side GPIO controllers, A and B. Each side keeps its own registers: a per-pin ATR/manual select, a direction mask, a manual output value, and four automatic transmit/receive values. Each side watches its radio's receive-active and transmit-active inputs and works out a value and an output enable for every pin.

A per-pin source register picks which side drives each pin. Software writes all registers over a simple masked-write bus, and can read them back with a combinational read port. The pad inputs pass through a synchronizer and can then be read at their own address. Pin outputs and output enables leave the block through flops.

Top module: `gpio_src_steer`

## Requirements
- R1: After reset every register reads 0, so every pin is sourced from radio A, and pin_out and pin_oe are 0.
- R2: The source register holds one 2-bit field per pin. Pin n's field is at bits [2n+1:2n], with pin 0 in the lowest field. Field bit 2n equal to 0 selects side A for pin n, and 1 selects side B.
- R3: Field values 2 and 3 steer the pin the same way as 0 and 1 (bit 2n+1 is ignored for steering). Readback still returns the stored field unchanged.
- R4: On each side, a select bit of 1 makes that pin take the chosen ATR value. A select bit of 0 makes it take the manual output bit.
- R5: On each side, the ATR value comes from that radio's {tx,rx} inputs: 00 uses the idle value, 01 the receive value, 10 the transmit value, and 11 the full-duplex value.
- R6: pin_oe[n] equals the direction bit (1 = output) of the side that drives pin n.
- R7: A write changes only the register bits whose wr_mask bit is 1. All other bits keep their value.
- R8: The source register is written at address 16 and read back unchanged at address 17. A write to address 17 has no effect. Unmapped addresses read 0.
- R9: Side A's registers are at addresses 0..6 and side B's at 8..14, in this order: select 0, direction 1, manual output 2, idle 3, receive 4, transmit 5, full-duplex 6. All of them read back, with the unused upper bits read as 0.
- R10: pin_out and pin_oe are registered. A register write or a radio-state change shows up on them at the clock edge after the one that captured it.
- R11: pin_in passes through two flops. Address 18 reads the synchronized value, so a change on pin_in shows at address 18 two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| radio_a_rx | input | 1 | Radio A receive active |
| radio_a_tx | input | 1 | Radio A transmit active |
| radio_b_rx | input | 1 | Radio B receive active |
| radio_b_tx | input | 1 | Radio B transmit active |
| pin_in | input | 12 | Pad input levels |
| pin_out | output | 12 | Registered pad output values |
| pin_oe | output | 12 | Registered pad output enables |

## Verification
The assertions check these behaviours on every cycle:
- Bits outside the write mask never change, and the source register holds steady unless it is written at its own address.
- A side's output enable moves only when its direction register is written.
- A pin driven manually stays steady while its registers stay steady.
- A pad enable is never raised unless one of the sides asked for it.

Some behaviours only the bench scenarios can show: the exact steering per field position, the ignored upper field bit, the ATR choice for each radio state, the one-cycle output latency and the two-cycle input latency. The bench shows these by comparing against a behavioural model every cycle.

// File: rtl/gss_pkg.sv
package gss_pkg;
   localparam int SIDE_REGS = 7;
   typedef enum logic [2:0] {
      RG_SEL      = 3'd0,
      RG_DIR      = 3'd1,
      RG_MAN      = 3'd2,
      RG_ATR_IDLE = 3'd3,
      RG_ATR_RX   = 3'd4,
      RG_ATR_TX   = 3'd5,
      RG_ATR_FDX  = 3'd6
   } side_reg_e;

   function automatic int atr_slot(input logic rx, input logic tx);
      return int'(RG_ATR_IDLE) + int'({tx, rx});
   endfunction
endpackage

// File: rtl/gss_side_regs.sv
module gss_side_regs
   import gss_pkg::*;
#(
   parameter int PINS   = 12,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              rx,
   input  logic              tx,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_val,
   output logic [PINS-1:0]   val_o,
   output logic [PINS-1:0]   oe_o
);
   logic [SIDE_REGS-1:0][PINS-1:0] regs_q;
   logic [PINS-1:0] atr_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (wr_en) begin
         for (int r = 0; r < SIDE_REGS; r++) begin
            if (wr_addr == ADDR_W'(BASE + r))
               regs_q[r] <= (regs_q[r] & ~wr_mask[PINS-1:0])
                          | (wr_data[PINS-1:0] & wr_mask[PINS-1:0]);
         end
      end
   end

   always_comb begin
      atr_val = regs_q[atr_slot(rx, tx)];
      val_o   = (regs_q[RG_SEL] & atr_val) | (~regs_q[RG_SEL] & regs_q[RG_MAN]);
      oe_o    = regs_q[RG_DIR];
   end

   always_comb begin
      rd_hit = 1'b0;
      rd_val = '0;
      for (int r = 0; r < SIDE_REGS; r++) begin
         if (rd_addr == ADDR_W'(BASE + r)) begin
            rd_hit = 1'b1;
            rd_val = DATA_W'(regs_q[r]);
         end
      end
   end

   // R4: a fully manual side keeps its value steady while its registers stay steady
   p_manual_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(regs_q[RG_SEL]) && regs_q[RG_SEL] == '0 && $stable(regs_q[RG_MAN]))
      |-> $stable(val_o));

   // R6: the enables move only on a write to the direction register
   p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(BASE + int'(RG_DIR))) |=> $stable(oe_o));
endmodule

// File: rtl/gss_sync.sv
module gss_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) st_q[0] <= '0;
               else        st_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) st_q[s] <= '0;
               else        st_q[s] <= st_q[s-1];
            end
         end
      end
   endgenerate

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/gss_src_mux.sv
module gss_src_mux #(
   parameter int PINS    = 12,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int WR_ADDR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [PINS-1:0]   val_a,
   input  logic [PINS-1:0]   oe_a,
   input  logic [PINS-1:0]   val_b,
   input  logic [PINS-1:0]   oe_b,
   output logic [2*PINS-1:0] src_o,
   output logic [PINS-1:0]   pin_out_o,
   output logic [PINS-1:0]   pin_oe_o
);
   localparam int SRC_W = 2 * PINS;

   logic [SRC_W-1:0] src_q;
   logic [PINS-1:0]  pick_b;
   logic             src_wr;

   assign src_wr = wr_en && (wr_addr == ADDR_W'(WR_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n)      src_q <= '0;
      else if (src_wr) src_q <= (src_q & ~wr_mask[SRC_W-1:0])
                              | (wr_data[SRC_W-1:0] & wr_mask[SRC_W-1:0]);
   end

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pick
         assign pick_b[p] = src_q[2*p];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_out_o <= '0;
         pin_oe_o  <= '0;
      end else begin
         pin_out_o <= (pick_b & val_b) | (~pick_b & val_a);
         pin_oe_o  <= (pick_b & oe_b)  | (~pick_b & oe_a);
      end
   end

   assign src_o = src_q;

   // R7: bits outside the mask survive a write to the source register
   p_src_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      src_wr |=> ((src_q ^ $past(src_q)) & ~$past(wr_mask[SRC_W-1:0])) == '0);

   // R8: the source register moves only on a write to its own address
   p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !src_wr |=> $stable(src_q));

   // R6: a pad is never enabled unless some side asked for it
   p_oe_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pin_oe_o & ~$past(oe_a | oe_b)) == '0);
endmodule

// File: rtl/gpio_src_steer.sv
module gpio_src_steer
   import gss_pkg::*;
#(
   parameter int PINS        = 12,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SIDE_B_BASE = 8,
   parameter int SRC_WR_ADDR = 16,
   parameter int SRC_RD_ADDR = 17,
   parameter int PIN_RD_ADDR = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              radio_a_rx,
   input  logic              radio_a_tx,
   input  logic              radio_b_rx,
   input  logic              radio_b_tx,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);
   localparam int SIDES = 2;
   localparam int SRC_W = 2 * PINS;

   generate
      if (SRC_W > DATA_W) begin : g_bad_width
         $error("source fields do not fit in the data word");
      end
      if (SIDE_B_BASE < SIDE_REGS) begin : g_bad_base
         $error("side B window overlaps side A");
      end
      if (SRC_WR_ADDR < SIDE_B_BASE + SIDE_REGS || SRC_RD_ADDR == SRC_WR_ADDR
          || PIN_RD_ADDR == SRC_RD_ADDR || PIN_RD_ADDR == SRC_WR_ADDR) begin : g_bad_map
         $error("address map collision");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
   endgenerate

   logic [SIDES-1:0]             side_rx, side_tx, side_hit;
   logic [SIDES-1:0][PINS-1:0]   side_val, side_oe;
   logic [SIDES-1:0][DATA_W-1:0] side_rd;
   logic [SRC_W-1:0]             src;
   logic [PINS-1:0]              pin_sync;

   assign side_rx = {radio_b_rx, radio_a_rx};
   assign side_tx = {radio_b_tx, radio_a_tx};

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         gss_side_regs #(
            .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
            .BASE(s * SIDE_B_BASE)
         ) u_side (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
            .rx(side_rx[s]), .tx(side_tx[s]),
            .rd_addr(rd_addr), .rd_hit(side_hit[s]), .rd_val(side_rd[s]),
            .val_o(side_val[s]), .oe_o(side_oe[s])
         );
      end
   endgenerate

   gss_src_mux #(
      .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_ADDR(SRC_WR_ADDR)
   ) u_mux (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .val_a(side_val[0]), .oe_a(side_oe[0]),
      .val_b(side_val[1]), .oe_b(side_oe[1]),
      .src_o(src), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
   );

   gss_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   always_comb begin
      rd_data = '0;
      if (side_hit[0])                             rd_data = side_rd[0];
      else if (side_hit[1])                        rd_data = side_rd[1];
      else if (rd_addr == ADDR_W'(SRC_RD_ADDR))    rd_data = DATA_W'(src);
      else if (rd_addr == ADDR_W'(PIN_RD_ADDR))    rd_data = DATA_W'(pin_sync);
   end

   // R1: the cycle after reset, no pad is enabled
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/gpio_src_steer_bench.sv
module gpio_src_steer_bench;
   localparam int P = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] wr_mask = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        a_rx = 1'b0, a_tx = 1'b0, b_rx = 1'b0, b_tx = 1'b0;
   logic [P-1:0] pin_in = '0;
   logic [P-1:0] pin_out, pin_oe;

   int n_cmp = 0, n_bad = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   gpio_src_steer u_gpio_src_steer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data),
      .radio_a_rx(a_rx), .radio_a_tx(a_tx), .radio_b_rx(b_rx), .radio_b_tx(b_tx),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // behavioural model
   logic [P-1:0] m_reg [2][7];
   logic [23:0]  m_src;
   logic [P-1:0] m_s1, m_s2, m_out, m_oe;

   function automatic logic [P-1:0] side_value(int s, logic rx, logic tx);
      logic [P-1:0] v;
      int slot = 3 + (tx ? 2 : 0) + (rx ? 1 : 0);
      for (int p = 0; p < P; p++)
         v[p] = m_reg[s][0][p] ? m_reg[s][slot][p] : m_reg[s][2][p];
      return v;
   endfunction

   function automatic logic [31:0] model_read(logic [4:0] a);
      if (a <= 6)                return 32'(m_reg[0][a]);
      if (a >= 8 && a <= 14)     return 32'(m_reg[1][a - 8]);
      if (a == 17)               return 32'(m_src);
      if (a == 18)               return 32'(m_s2);
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < 2; s++) for (int r = 0; r < 7; r++) m_reg[s][r] = '0;
         m_src = '0; m_s1 = '0; m_s2 = '0; m_out = '0; m_oe = '0;
      end else begin
         logic [P-1:0] va, vb;
         va = side_value(0, a_rx, a_tx);
         vb = side_value(1, b_rx, b_tx);
         for (int p = 0; p < P; p++) begin
            m_out[p] = m_src[2*p] ? vb[p] : va[p];
            m_oe[p]  = m_src[2*p] ? m_reg[1][1][p] : m_reg[0][1][p];
         end
         if (wr_en) begin
            if (wr_addr <= 6)
               m_reg[0][wr_addr] = (m_reg[0][wr_addr] & ~wr_mask[P-1:0]) | (wr_data[P-1:0] & wr_mask[P-1:0]);
            else if (wr_addr >= 8 && wr_addr <= 14)
               m_reg[1][wr_addr-8] = (m_reg[1][wr_addr-8] & ~wr_mask[P-1:0]) | (wr_data[P-1:0] & wr_mask[P-1:0]);
            else if (wr_addr == 16)
               m_src = (m_src & ~wr_mask[23:0]) | (wr_data[23:0] & wr_mask[23:0]);
         end
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
   end

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // compare every cycle, away from both edges
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         check("pin_out", 32'(pin_out), 32'(m_out));
         check("pin_oe", 32'(pin_oe), 32'(m_oe));
         check("rd_data", rd_data, model_read(rd_addr));
      end
   end

   task automatic wr(logic [4:0] a, logic [31:0] d, logic [31:0] m);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_hold(logic [4:0] a, int cyc);
      rd_addr = a;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic radio(logic ar, logic at, logic br, logic bt);
      @(negedge clk);
      {a_rx, a_tx, b_rx, b_tx} = {ar, at, br, bt};
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state readback and quiet pads
      tag = "R1";
      #2;
      check("reset pin_oe", 32'(pin_oe), 32'h0);
      check("reset src", model_read(17), 32'h0);
      rd_hold(17, 1); rd_hold(1, 1); rd_hold(9, 1);
      // R9: both register sets written and read back
      tag = "R9";
      for (int r = 0; r < 7; r++) begin
         wr(5'(r), 32'hFFFF_F000 | 32'(12'h111 * (r + 1)), 32'hFFFF_FFFF);
         wr(5'(8 + r), 32'(12'h0F0 ^ (r * 12'h123)), 32'hFFFF_FFFF);
      end
      for (int a = 0; a < 20; a++) rd_hold(5'(a), 1);
      // R4: manual vs ATR per pin on side A
      tag = "R4";
      wr(0, 32'h0F0, 32'hFFF);
      wr(1, 32'hFFF, 32'hFFF);
      wr(2, 32'hA5A, 32'hFFF);
      rd_hold(0, 3);
      // R5: each radio state selects its ATR value
      tag = "R5";
      radio(0, 0, 0, 0); radio(1, 0, 0, 1); radio(0, 1, 1, 0); radio(1, 1, 1, 1);
      wr(0, 32'hFFF, 32'hFFF);
      wr(8, 32'hFFF, 32'hFFF);
      radio(0, 0, 1, 1); radio(1, 0, 0, 0); radio(0, 1, 0, 1); radio(1, 1, 1, 0);
      // R2: field positions, pin 0 then pin 11 steered to side B
      tag = "R2";
      wr(16, 32'h000001, 32'hFFFFFF); rd_hold(17, 2);
      wr(16, 32'h400000, 32'hFFFFFF); rd_hold(17, 2);
      wr(16, 32'h555000, 32'hFFFFFF); rd_hold(17, 2);
      // R6: direction differs per side
      tag = "R6";
      wr(1, 32'h0F0, 32'hFFF);
      wr(9, 32'hF0F, 32'hFFF);
      rd_hold(9, 3);
      // R3: codes 2 and 3 act as 0 and 1, readback unchanged
      tag = "R3";
      wr(16, 32'hAAAAAA, 32'hFFFFFF); rd_hold(17, 2);
      wr(16, 32'hFFFFFF, 32'hFFFFFF); rd_hold(17, 2);
      // R7: masked writes
      tag = "R7";
      wr(16, 32'h000000, 32'h00F00F); rd_hold(17, 2);
      wr(2, 32'h000, 32'h00F); rd_hold(2, 2);
      wr(10, 32'hFFF, 32'h800); rd_hold(10, 2);
      // R8: write to readback address ignored; unmapped reads zero
      tag = "R8";
      wr(17, 32'h000000, 32'hFFFFFF); rd_hold(17, 2);
      rd_hold(7, 1); rd_hold(15, 1); rd_hold(16, 1); rd_hold(31, 1);
      // R10: output latency after a radio change
      tag = "R10";
      radio(0, 0, 0, 0); radio(1, 1, 0, 0);
      // R11: input synchronizer latency
      tag = "R11";
      rd_addr = 18;
      @(negedge clk); pin_in = 12'hC35;
      repeat (3) @(negedge clk);
      pin_in = 12'h3CA;
      repeat (3) @(negedge clk);
      // mixed traffic
      tag = "R10";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         wr_en   = ($urandom % 3) == 0;
         wr_addr = 5'($urandom % 19);
         wr_data = $urandom;
         wr_mask = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
         rd_addr = 5'($urandom % 20);
         {a_rx, a_tx, b_rx, b_tx} = 4'($urandom);
         pin_in  = P'($urandom);
      end
      @(negedge clk); wr_en = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule